// File: doc/BRIEF.md
# Virtual Channel Class Selector

This block picks an outgoing port and virtual channel for the head flit of a packet at a router in a two-dimensional mesh. Every physical link carries five virtual channels with fixed roles. Channels 0 and 1 are minimal-adaptive. Channels 2 and 3 are deterministic X-then-Y channels: 2 is the low-priority level and 3 the high-priority level. Channel 4 is a non-minimal escape channel under west-first turn rules. The block looks at the packet's destination, the router's own coordinates, one free flag for each (port, channel) pair, one fault flag for each port, the packet's priority bit, whether the packet already travels on a deterministic channel, and the direction it travelled on its last hop.

The order of preference is fixed. First comes a free adaptive channel on any healthy port that brings the packet closer. If there is none, the block takes the deterministic channel matching the packet's priority on the X-first port. The escape channel is used only when every productive port is faulty. A packet that is already on a deterministic channel is never given an adaptive channel again. When nothing legal is free, the block answers with a stall. The caller clears the free flag of the channel that was granted.

Requests enter on a valid/ready channel, and each request yields one registered answer on a valid/ready result channel. `req_ready` is high when the result register is empty, or when its content is being taken in the same cycle. An answer that is not taken stays unchanged until `res_ready` is high. A request is accepted on a rising clock edge with `req_valid` and `req_ready` both high, and its answer is visible from the next cycle. A stall is an answer like any other and uses the same handshake. Flags and coordinates are sampled only at acceptance.

Top module: `vc_class_selector`

## Requirements
- R1: Port codes are 0 local, 1 east (+x), 2 west (-x), 3 north (+y), 4 south (-y). A port is productive when it reduces the distance to the destination, and the local port is the only productive port when the destination equals the router's coordinates. If the packet is not on a deterministic channel, the answer is the first healthy productive port, scanning ports 0 to 4, that has channel 0 or 1 free, with channel 0 preferred.
- R2: If no adaptive channel qualifies, the answer is the X-first port: east or west while the X coordinates differ, otherwise north or south, and local at the destination. The channel is 2 when the priority bit is 0 and 3 when it is 1, provided that port is healthy and that channel is free.
- R3: A request with `req_on_dor`=1 is never answered with channel 0 or 1.
- R4: Channel 4 is granted only when the packet is not at its destination and every productive port is faulty. The granted port is then the first mesh port (1 to 4) that is healthy, has channel 4 free, is not the reverse of `req_travel_dir`, and is west only if `req_travel_dir` is 0 (just injected) or 2 (west).
- R5: A granted answer never names a port whose fault flag was set, nor a channel whose free flag (`vc_free` bit port*5+channel) was clear, at acceptance.
- R6: When no rule above yields a channel, the answer has `res_stall`=1 with port and channel 0.
- R7: `req_ready` equals NOT `res_valid` OR `res_ready`. An answer held with `res_ready` low keeps `res_stall`, `res_port` and `res_vc` unchanged.
- R8: After reset `res_valid` is 0 and `req_ready` is 1.
- R9: At the destination only the local port may be granted. If the local port is faulty the answer is a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_x | input | COORD_W | X coordinate of this router |
| loc_y | input | COORD_W | Y coordinate of this router |
| req_valid | input | 1 | Head-flit request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_dst_x | input | COORD_W | Destination X |
| req_dst_y | input | COORD_W | Destination Y |
| req_prio | input | 1 | Packet priority (0 low, 1 high) |
| req_on_dor | input | 1 | Packet already on a deterministic channel |
| req_travel_dir | input | 3 | Direction of last hop (port code, 0 = injected) |
| vc_free | input | 25 | Free flag, bit port*5+channel |
| port_fault | input | 5 | Fault flag per port code |
| res_valid | output | 1 | Answer valid |
| res_ready | input | 1 | Consumer takes the answer |
| res_stall | output | 1 | No legal channel free |
| res_port | output | 3 | Granted output port code |
| res_vc | output | 3 | Granted channel index 0..4 |

## Verification
The bench aims at the edges between the three channel classes. It covers an adaptive scan that must skip a busy or faulty port, the deterministic fallback where the X-first port is faulty while another productive port is healthy (the answer must be a stall, not an escape), packets already on a deterministic channel that see free adaptive channels, and west-first or U-turn cases where the escape channel has to refuse a port. A design that mixes up the priority levels, re-enters the adaptive class, or escapes too early sends back a different port or channel, and the scoreboard flags the mismatch. Random traffic under periodic back-pressure looks for answers that change while held, or that name a faulty port or a busy channel.

// File: rtl/vcs_pkg.sv
package vcs_pkg;
  localparam int NPORT = 5;
  localparam int NVC = 5;
  localparam int PW = 3;
  localparam int VW = 3;
  localparam int FREE_W = NPORT * NVC;

  localparam int P_LOC = 0;
  localparam int P_E = 1;
  localparam int P_W = 2;
  localparam int P_N = 3;
  localparam int P_S = 4;

  localparam int N_ADP = 2;
  localparam int VC_DOR_LO = 2;
  localparam int VC_DOR_HI = 3;
  localparam int VC_ESC = 4;

  typedef struct packed {
    logic          stall;
    logic [PW-1:0] port;
    logic [VW-1:0] vc;
  } pick_t;

  function automatic logic [PW-1:0] rev_dir(input logic [PW-1:0] d);
    case (d)
      PW'(P_E): rev_dir = PW'(P_W);
      PW'(P_W): rev_dir = PW'(P_E);
      PW'(P_N): rev_dir = PW'(P_S);
      PW'(P_S): rev_dir = PW'(P_N);
      default:  rev_dir = PW'(P_LOC);
    endcase
  endfunction
endpackage

// File: rtl/vcs_route_set.sv
module vcs_route_set
  import vcs_pkg::*;
#(
  parameter int COORD_W = 3
) (
  input  logic [COORD_W-1:0] loc_x,
  input  logic [COORD_W-1:0] loc_y,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  output logic [NPORT-1:0]   prod,
  output logic [PW-1:0]      dor_port,
  output logic               at_dest
);
  logic go_e, go_w, go_n, go_s;

  assign go_e    = dst_x > loc_x;
  assign go_w    = dst_x < loc_x;
  assign go_n    = dst_y > loc_y;
  assign go_s    = dst_y < loc_y;
  assign at_dest = !(go_e || go_w || go_n || go_s);

  always_comb begin
    prod        = '0;
    prod[P_LOC] = at_dest;
    prod[P_E]   = go_e;
    prod[P_W]   = go_w;
    prod[P_N]   = go_n;
    prod[P_S]   = go_s;
  end

  always_comb begin
    if (go_e)      dor_port = PW'(P_E);
    else if (go_w) dor_port = PW'(P_W);
    else if (go_n) dor_port = PW'(P_N);
    else if (go_s) dor_port = PW'(P_S);
    else           dor_port = PW'(P_LOC);
  end
endmodule

// File: rtl/vcs_adaptive_pick.sv
module vcs_adaptive_pick
  import vcs_pkg::*;
(
  input  logic [NPORT-1:0]  healthy_prod,
  input  logic [FREE_W-1:0] vc_free,
  output logic              hit,
  output logic [PW-1:0]     port,
  output logic [VW-1:0]     vc
);
  always_comb begin
    hit  = 1'b0;
    port = '0;
    vc   = '0;
    for (int p = 0; p < NPORT; p++) begin
      for (int v = 0; v < N_ADP; v++) begin
        if (!hit && healthy_prod[p] && vc_free[p*NVC+v]) begin
          hit  = 1'b1;
          port = PW'(p);
          vc   = VW'(v);
        end
      end
    end
  end
endmodule

// File: rtl/vcs_escape_pick.sv
module vcs_escape_pick
  import vcs_pkg::*;
(
  input  logic              enable,
  input  logic [PW-1:0]     travel_dir,
  input  logic [NPORT-1:0]  port_fault,
  input  logic [FREE_W-1:0] vc_free,
  output logic              hit,
  output logic [PW-1:0]     port
);
  logic [NPORT-1:0] allow;
  logic [PW-1:0]    back;
  logic             west_ok;

  assign back    = rev_dir(travel_dir);
  assign west_ok = (travel_dir == PW'(P_LOC)) || (travel_dir == PW'(P_W));

  genvar g;
  generate
    for (g = 0; g < NPORT; g++) begin : g_allow
      if (g == P_LOC) begin : g_loc
        assign allow[g] = 1'b0;
      end else begin : g_mesh
        assign allow[g] = enable && !port_fault[g] && vc_free[g*NVC+VC_ESC] &&
                          (back != PW'(g)) && ((g != P_W) || west_ok);
      end
    end
  endgenerate

  always_comb begin
    hit  = 1'b0;
    port = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (!hit && allow[p]) begin
        hit  = 1'b1;
        port = PW'(p);
      end
    end
  end
endmodule

// File: rtl/vc_class_selector.sv
module vc_class_selector
  import vcs_pkg::*;
#(
  parameter int COORD_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [COORD_W-1:0]    loc_x,
  input  logic [COORD_W-1:0]    loc_y,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [COORD_W-1:0]    req_dst_x,
  input  logic [COORD_W-1:0]    req_dst_y,
  input  logic                  req_prio,
  input  logic                  req_on_dor,
  input  logic [2:0]            req_travel_dir,
  input  logic [24:0]           vc_free,
  input  logic [4:0]            port_fault,
  output logic                  res_valid,
  input  logic                  res_ready,
  output logic                  res_stall,
  output logic [2:0]            res_port,
  output logic [2:0]            res_vc
);
  logic [NPORT-1:0] prod, healthy_prod;
  logic [PW-1:0]    dor_port, adp_port, esc_port;
  logic [VW-1:0]    adp_vc, dor_vc;
  logic             at_dest, adp_hit, dor_hit, esc_hit, esc_en;
  pick_t            pick, res_q;

  vcs_route_set #(.COORD_W(COORD_W)) u_route (
    .loc_x(loc_x), .loc_y(loc_y), .dst_x(req_dst_x), .dst_y(req_dst_y),
    .prod(prod), .dor_port(dor_port), .at_dest(at_dest)
  );

  assign healthy_prod = prod & ~port_fault;

  vcs_adaptive_pick u_adp (
    .healthy_prod(req_on_dor ? '0 : healthy_prod), .vc_free(vc_free),
    .hit(adp_hit), .port(adp_port), .vc(adp_vc)
  );

  assign dor_vc  = req_prio ? VW'(VC_DOR_HI) : VW'(VC_DOR_LO);
  assign dor_hit = !port_fault[dor_port] && vc_free[dor_port*NVC+dor_vc];
  assign esc_en  = !at_dest && (healthy_prod == '0);

  vcs_escape_pick u_esc (
    .enable(esc_en), .travel_dir(req_travel_dir), .port_fault(port_fault),
    .vc_free(vc_free), .hit(esc_hit), .port(esc_port)
  );

  always_comb begin
    pick = '{stall: 1'b1, port: '0, vc: '0};
    if (adp_hit)      pick = '{stall: 1'b0, port: adp_port, vc: adp_vc};
    else if (dor_hit) pick = '{stall: 1'b0, port: dor_port, vc: dor_vc};
    else if (esc_hit) pick = '{stall: 1'b0, port: esc_port, vc: VW'(VC_ESC)};
  end

  assign req_ready = !res_valid || res_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_q     <= '0;
    end else if (req_valid && req_ready) begin
      res_valid <= 1'b1;
      res_q     <= pick;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  assign res_stall = res_q.stall;
  assign res_port  = res_q.port;
  assign res_vc    = res_q.vc;
endmodule

// File: rtl/vcs_chk.sv
module vcs_chk #(
  parameter int COORD_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [COORD_W-1:0] loc_x,
  input logic [COORD_W-1:0] loc_y,
  input logic               req_valid,
  input logic               req_ready,
  input logic [COORD_W-1:0] req_dst_x,
  input logic [COORD_W-1:0] req_dst_y,
  input logic               req_prio,
  input logic               req_on_dor,
  input logic [2:0]         req_travel_dir,
  input logic [24:0]        vc_free,
  input logic [4:0]         port_fault,
  input logic               res_valid,
  input logic               res_ready,
  input logic               res_stall,
  input logic [2:0]         res_port,
  input logic [2:0]         res_vc
);
  logic        c_dor, c_prio, c_dest;
  logic [2:0]  c_dir;
  logic [24:0] c_free;
  logic [4:0]  c_fault;
  logic        grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_dor <= 1'b0; c_prio <= 1'b0; c_dest <= 1'b0;
      c_dir <= '0; c_free <= '0; c_fault <= '0;
    end else if (req_valid && req_ready) begin
      c_dor   <= req_on_dor;
      c_prio  <= req_prio;
      c_dest  <= (req_dst_x == loc_x) && (req_dst_y == loc_y);
      c_dir   <= req_travel_dir;
      c_free  <= vc_free;
      c_fault <= port_fault;
    end
  end

  assign grant = res_valid && !res_stall;

  AST_NO_READAPT: assert property (@(posedge clk) disable iff (!rst_n)
    grant && c_dor |-> res_vc >= 3'd2); // R3
  AST_LEGAL_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> !c_fault[res_port] && c_free[res_port*5+res_vc]); // R5
  AST_DOR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    grant && (res_vc == 3'd2 || res_vc == 3'd3) |-> res_vc == {2'b01, c_prio}); // R2
  AST_ESC_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    grant && res_vc == 3'd4 |-> res_port != 3'd0 &&
      (res_port != 3'd2 || c_dir == 3'd0 || c_dir == 3'd2)); // R4
  AST_EJECT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    grant && c_dest |-> res_port == 3'd0); // R9
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_stall) &&
      $stable(res_port) && $stable(res_vc)); // R7
endmodule

bind vc_class_selector vcs_chk #(.COORD_W(COORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .loc_x(loc_x), .loc_y(loc_y),
  .req_valid(req_valid), .req_ready(req_ready), .req_dst_x(req_dst_x),
  .req_dst_y(req_dst_y), .req_prio(req_prio), .req_on_dor(req_on_dor),
  .req_travel_dir(req_travel_dir), .vc_free(vc_free), .port_fault(port_fault),
  .res_valid(res_valid), .res_ready(res_ready), .res_stall(res_stall),
  .res_port(res_port), .res_vc(res_vc)
);

// File: tb/vc_class_selector_tb.sv
module vc_class_selector_tb;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] loc_x = 3'd3, loc_y = 3'd3;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [CW-1:0] req_dst_x = '0, req_dst_y = '0;
  logic          req_prio = 1'b0, req_on_dor = 1'b0;
  logic [2:0]    req_travel_dir = '0;
  logic [24:0]   vc_free = '0;
  logic [4:0]    port_fault = '0;
  logic          res_valid;
  logic          res_ready = 1'b1;
  logic          res_stall;
  logic [2:0]    res_port, res_vc;

  int total = 0, bad = 0;
  logic [6:0] exp_q[$];
  string      tag_q[$];
  logic       bp_en = 1'b0;
  int         rdy_cnt = 0;

  always #2.5 clk = ~clk;

  vc_class_selector #(.COORD_W(CW)) u_dut (.*);

  always @(posedge clk) begin
    rdy_cnt <= rdy_cnt + 1;
    res_ready <= bp_en ? ((rdy_cnt % 4) != 3) : 1'b1;
  end

  function automatic logic [6:0] model(input int dx, dy, lx, ly, input logic prio,
      input logic dor, input int dir, input logic [4:0] flt, input logic [24:0] fr);
    logic [4:0] pr;
    int dp, back;
    pr = '0;
    pr[1] = dx > lx; pr[2] = dx < lx; pr[3] = dy > ly; pr[4] = dy < ly;
    pr[0] = (pr[4:1] == 0);
    if (!dor)
      for (int p = 0; p < 5; p++)
        for (int v = 0; v < 2; v++)
          if (pr[p] && !flt[p] && fr[p*5+v]) return {1'b0, 3'(p), 3'(v)};
    dp = pr[1] ? 1 : pr[2] ? 2 : pr[3] ? 3 : pr[4] ? 4 : 0;
    if (!flt[dp] && fr[dp*5+2+int'(prio)]) return {1'b0, 3'(dp), 3'(2 + int'(prio))};
    if (!pr[0] && ((pr & ~flt) == 0)) begin
      back = (dir == 1) ? 2 : (dir == 2) ? 1 : (dir == 3) ? 4 : (dir == 4) ? 3 : 0;
      for (int p = 1; p < 5; p++)
        if (!flt[p] && fr[p*5+4] && p != back && (p != 2 || dir == 0 || dir == 2))
          return {1'b0, 3'(p), 3'd4};
    end
    return 7'b1000000;
  endfunction

  task automatic send(input string tag, input int dx, dy, input logic prio, dor,
                      input int dir, input logic [4:0] flt, input logic [24:0] fr);
    @(negedge clk);
    req_dst_x = CW'(dx); req_dst_y = CW'(dy); req_prio = prio; req_on_dor = dor;
    req_travel_dir = 3'(dir); port_fault = flt; vc_free = fr; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    exp_q.push_back(model(dx, dy, int'(loc_x), int'(loc_y), prio, dor, dir, flt, fr));
    tag_q.push_back(tag);
    @(posedge clk);
    #0.5 req_valid = 1'b0;
  endtask

  logic       hold_pend = 1'b0;
  logic [6:0] hold_val;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        total++;
        if ({res_valid, res_stall, res_port, res_vc} != {1'b1, hold_val}) begin
          bad++;
          $display("FAIL R7 held answer changed: actual=%b expected=%b",
                   {res_valid, res_stall, res_port, res_vc}, {1'b1, hold_val});
        end
      end
      hold_pend = res_valid && !res_ready;
      hold_val  = {res_stall, res_port, res_vc};
      if (res_valid && res_ready) begin
        logic [6:0] e;
        string t;
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R7 unexpected answer: actual=%b expected=none",
                   {res_stall, res_port, res_vc});
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({res_stall, res_port, res_vc} != e) begin
            bad++;
            $display("FAIL %s stall/port/vc: actual=%b/%0d/%0d expected=%b/%0d/%0d",
                     t, res_stall, res_port, res_vc, e[6], e[5:3], e[2:0]);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R7: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  localparam logic [24:0] ALL = '1;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (res_valid !== 1'b0 || req_ready !== 1'b1) begin
      bad++;
      $display("FAIL R8 reset: actual=%b%b expected=01", res_valid, req_ready);
    end
    // R1 adaptive east, channel 0
    send("R1", 5, 3, 0, 0, 0, 5'b0, ALL);
    // R1 east adaptive busy, north adaptive taken
    send("R1", 5, 5, 0, 0, 1, 5'b0, ALL & ~(25'b11 << 5));
    // R1 channel 1 when channel 0 busy
    send("R1", 3, 1, 0, 0, 0, 5'b0, ALL & ~(25'b1 << 20));
    // R2 fallback low and high priority
    send("R2", 5, 3, 0, 0, 0, 5'b0, ALL & ~(25'b11 << 5));
    send("R2", 5, 3, 1, 0, 0, 5'b0, ALL & ~(25'b11 << 5));
    // R2 X-first port west while Y also differs
    send("R2", 1, 6, 1, 0, 0, 5'b0, ALL & ~(25'b11 << 10) & ~(25'b11 << 15));
    // R3 already deterministic: ignore free adaptive channels
    send("R3", 5, 5, 0, 1, 1, 5'b0, ALL);
    send("R3", 5, 5, 1, 1, 1, 5'b0, ALL & ~(25'b1 << 8));
    // R5 east faulty, north adaptive
    send("R5", 5, 5, 0, 0, 0, 5'b00010, ALL);
    // R6 east (X-first) faulty, north adaptive busy: stall, no escape
    send("R6", 5, 5, 0, 0, 0, 5'b00010, ALL & ~(25'b11 << 15));
    // R4 all productive faulty, travelling east: west banned, north chosen
    send("R4", 5, 3, 0, 0, 1, 5'b00010, ALL);
    // R4 travelling north toward north fault, east busy: stall
    send("R4", 3, 5, 0, 0, 3, 5'b01000, ALL & ~(25'b1 << 9));
    // R4 travelling west: west allowed, east is U-turn
    send("R4", 3, 5, 0, 0, 2, 5'b01000, ALL);
    // R4 injected, west-bound with west faulty: east escape
    send("R4", 1, 3, 0, 1, 0, 5'b00100, ALL);
    // R9 ejection and faulty local port
    send("R9", 3, 3, 0, 0, 4, 5'b0, ALL);
    send("R9", 3, 3, 1, 1, 4, 5'b0, ALL);
    send("R9", 3, 3, 0, 0, 4, 5'b00001, ALL);
    // R6 nothing free at all
    send("R6", 6, 0, 1, 0, 0, 5'b0, 25'b0);
    // R5 random traffic under back-pressure
    bp_en = 1'b1;
    for (int i = 0; i < 300; i++) begin
      send("R5", int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
           1'($urandom), 1'($urandom), int'($urandom_range(0, 4)),
           5'($urandom) & 5'($urandom), 25'($urandom) | 25'($urandom));
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule